// File: doc/BRIEF.md
# Multiplexed LCD Common Scan Timer

This block derives the row-scan timing of a multiplexed dot-matrix LCD from the controller clock. It walks through the common rows of a frame and holds each row for a number of clocks that depends on the chosen duty. For every row it shows the active common as an index and as a one-hot vector. A one-clock strobe marks the start of each row, and segment data are latched on that strobe. A one-clock pulse marks the start of each frame.

Five duties are supported: 1/8, 1/9, 1/16, 1/17 and 1/25. The 1/9, 1/17 and 1/25 settings add one row for the icon line. That row is flagged on its own output. The common scan order can be reversed. A segment-direction select is carried to a registered output so that downstream segment logic can use it. A frame-polarity bit toggles once per frame for AC drive; the drive waveform itself is generated elsewhere. Changes of duty and of both direction selects are sampled only at a frame boundary, so a frame in progress always finishes in its old configuration.

Top module: `lcd_com_scan`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `com_onehot`, `row_idx`, `row_strobe`, `frame_start`, `frame_pol`, `icon_row` and `seg_dir` are all zero. The first rising edge with `rst` low begins a frame.
- R2: `duty_sel` codes select the row count: 0 gives 8 rows, 1 gives 9, 2 gives 16, 3 gives 17 and 4 gives 25. Codes 5, 6 and 7 behave exactly as code 2.
- R3: Each row lasts `ROW_CLK_8` clocks (default 400) for 8 or 9 rows, `ROW_CLK_16` clocks (default 200) for 16 or 17 rows, and `ROW_CLK_25` clocks (default 160) for 25 rows. `row_strobe` is high on the first clock of every row and low on all other clocks, and `row_idx` changes only on a strobe clock.
- R4: `frame_start` is high for exactly the first clock of each frame, and that clock also carries `row_strobe`. A frame lasts rows × row clocks.
- R5: `frame_pol` inverts on every frame-start clock and holds on all other clocks. The first frame after reset has `frame_pol` = 1.
- R6: With `com_rev` = 0 latched, `row_idx` steps 0, 1, … N−1. With `com_rev` = 1 latched, it steps N−1 down to 0. `com_onehot` has only bit `row_idx` set.
- R7: `icon_row` is high exactly when `row_idx` = N−1 in the 9-, 17- and 25-row settings, and is always low in the other settings.
- R8: `seg_dir` equals the value `seg_rev` had at the most recent frame-start clock.
- R9: A change of `duty_sel`, `com_rev` or `seg_rev` during a frame has no effect until the next frame start. The current frame completes with its latched settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_sel | input | 3 | Duty code, sampled at frame start |
| com_rev | input | 1 | Reverse common scan order, sampled at frame start |
| seg_rev | input | 1 | Segment direction select, sampled at frame start |
| com_onehot | output | MAX_ROWS (25) | One-hot active common row |
| row_idx | output | $clog2(MAX_ROWS) (5) | Index of the active common row |
| row_strobe | output | 1 | High on the first clock of each row |
| frame_start | output | 1 | High on the first clock of each frame |
| frame_pol | output | 1 | Frame polarity, inverts every frame |
| icon_row | output | 1 | Active row is the icon row |
| seg_dir | output | 1 | Latched segment direction |

## Verification
All outputs are registered from the next counter state, so each output describes the same clock as the counters behind it. The state for a given rising edge is visible right after that edge. The first frame starts on the first edge that samples `rst` low. The bench counts rising edges since reset release and samples each output on the following falling edge. From that count it works out the frame position as a quotient and remainder of the frame length and row length. Duty and direction inputs are changed only on falling edges, after the checks for that edge. The model applies the new values at the first frame boundary after the change, which matches the sampling point of the latched settings.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int DUTY_W   = 3;
  localparam int ROWCNT_W = 5;
  localparam int CLKCNT_W = 16;

  localparam logic [DUTY_W-1:0] DUTY_R8  = 3'd0;
  localparam logic [DUTY_W-1:0] DUTY_R9  = 3'd1;
  localparam logic [DUTY_W-1:0] DUTY_R16 = 3'd2;
  localparam logic [DUTY_W-1:0] DUTY_R17 = 3'd3;
  localparam logic [DUTY_W-1:0] DUTY_R25 = 3'd4;

  typedef struct packed {
    logic [ROWCNT_W-1:0] rows;
    logic [CLKCNT_W-1:0] row_clks;
    logic                ext;
  } duty_cfg_t;
endpackage

// File: rtl/lcd_duty_decode.sv
module lcd_duty_decode
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLK_8  = 400,
  parameter int ROW_CLK_16 = 200,
  parameter int ROW_CLK_25 = 160
) (
  input  logic [DUTY_W-1:0] code,
  output duty_cfg_t         cfg
);
  localparam logic [CLKCNT_W-1:0] C8  = CLKCNT_W'(ROW_CLK_8);
  localparam logic [CLKCNT_W-1:0] C16 = CLKCNT_W'(ROW_CLK_16);
  localparam logic [CLKCNT_W-1:0] C25 = CLKCNT_W'(ROW_CLK_25);

  always_comb begin
    case (code)
      DUTY_R8:  cfg = '{rows: ROWCNT_W'(8),  row_clks: C8,  ext: 1'b0};
      DUTY_R9:  cfg = '{rows: ROWCNT_W'(9),  row_clks: C8,  ext: 1'b1};
      DUTY_R17: cfg = '{rows: ROWCNT_W'(17), row_clks: C16, ext: 1'b1};
      DUTY_R25: cfg = '{rows: ROWCNT_W'(25), row_clks: C25, ext: 1'b1};
      default:  cfg = '{rows: ROWCNT_W'(16), row_clks: C16, ext: 1'b0};
    endcase
  end
endmodule

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLK_8  = 400,
  parameter int ROW_CLK_16 = 200,
  parameter int ROW_CLK_25 = 160
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DUTY_W-1:0]   duty_sel,
  output logic [ROWCNT_W-1:0] nxt_row,
  output logic                nxt_first,
  output logic                nxt_begin,
  output duty_cfg_t           nxt_cfg
);
  logic                run_q;
  logic [CLKCNT_W-1:0] clk_q, clk_d;
  logic [ROWCNT_W-1:0] row_q, row_d;
  logic [DUTY_W-1:0]   code_q, code_d;
  logic                row_end, frame_end;
  duty_cfg_t           cfg_cur, cfg_req;

  lcd_duty_decode #(.ROW_CLK_8(ROW_CLK_8), .ROW_CLK_16(ROW_CLK_16), .ROW_CLK_25(ROW_CLK_25))
    u_dec_cur (.code(code_q), .cfg(cfg_cur));
  lcd_duty_decode #(.ROW_CLK_8(ROW_CLK_8), .ROW_CLK_16(ROW_CLK_16), .ROW_CLK_25(ROW_CLK_25))
    u_dec_req (.code(duty_sel), .cfg(cfg_req));

  always_comb begin
    row_end   = (clk_q == cfg_cur.row_clks - 1'b1);
    frame_end = row_end && (row_q == cfg_cur.rows - 1'b1);
    nxt_begin = !run_q || frame_end;
    if (nxt_begin) begin
      clk_d  = '0;
      row_d  = '0;
      code_d = duty_sel;
    end else if (row_end) begin
      clk_d  = '0;
      row_d  = row_q + 1'b1;
      code_d = code_q;
    end else begin
      clk_d  = clk_q + 1'b1;
      row_d  = row_q;
      code_d = code_q;
    end
    nxt_first = (clk_d == '0);
    nxt_row   = row_d;
    nxt_cfg   = nxt_begin ? cfg_req : cfg_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      clk_q  <= '0;
      row_q  <= '0;
      code_q <= DUTY_R16;
    end else begin
      run_q  <= 1'b1;
      clk_q  <= clk_d;
      row_q  <= row_d;
      code_q <= code_d;
    end
  end
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_scan_pkg::*;
#(
  parameter int MAX_ROWS = 25,
  parameter int IDX_W    = $clog2(MAX_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROWCNT_W-1:0] nxt_row,
  input  logic                nxt_first,
  input  logic                nxt_begin,
  input  duty_cfg_t           nxt_cfg,
  input  logic                com_rev,
  input  logic                seg_rev,
  output logic [MAX_ROWS-1:0] com_onehot,
  output logic [IDX_W-1:0]    row_idx,
  output logic                row_strobe,
  output logic                frame_start,
  output logic                frame_pol,
  output logic                icon_row,
  output logic                seg_dir
);
  logic                rev_q, rev_eff;
  logic [ROWCNT_W-1:0] last_row, idx_d;
  logic [MAX_ROWS-1:0] hot_d;

  always_comb begin
    rev_eff  = nxt_begin ? com_rev : rev_q;
    last_row = nxt_cfg.rows - 1'b1;
    idx_d    = rev_eff ? (last_row - nxt_row) : nxt_row;
  end

  for (genvar g = 0; g < MAX_ROWS; g++) begin : g_hot
    assign hot_d[g] = (idx_d == ROWCNT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rev_q       <= 1'b0;
      com_onehot  <= '0;
      row_idx     <= '0;
      row_strobe  <= 1'b0;
      frame_start <= 1'b0;
      frame_pol   <= 1'b0;
      icon_row    <= 1'b0;
      seg_dir     <= 1'b0;
    end else begin
      rev_q       <= rev_eff;
      com_onehot  <= hot_d;
      row_idx     <= IDX_W'(idx_d);
      row_strobe  <= nxt_first;
      frame_start <= nxt_begin;
      icon_row    <= nxt_cfg.ext && (idx_d == last_row);
      if (nxt_begin) begin
        frame_pol <= ~frame_pol;
        seg_dir   <= seg_rev;
      end
    end
  end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int MAX_ROWS   = 25,
  parameter int ROW_CLK_8  = 400,
  parameter int ROW_CLK_16 = 200,
  parameter int ROW_CLK_25 = 160,
  parameter int IDX_W      = $clog2(MAX_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          duty_sel,
  input  logic                com_rev,
  input  logic                seg_rev,
  output logic [MAX_ROWS-1:0] com_onehot,
  output logic [IDX_W-1:0]    row_idx,
  output logic                row_strobe,
  output logic                frame_start,
  output logic                frame_pol,
  output logic                icon_row,
  output logic                seg_dir
);
  logic [ROWCNT_W-1:0] nxt_row;
  logic                nxt_first, nxt_begin;
  duty_cfg_t           nxt_cfg;

  lcd_row_timer #(
    .ROW_CLK_8(ROW_CLK_8), .ROW_CLK_16(ROW_CLK_16), .ROW_CLK_25(ROW_CLK_25)
  ) u_timer (
    .clk(clk), .rst(rst), .duty_sel(duty_sel),
    .nxt_row(nxt_row), .nxt_first(nxt_first), .nxt_begin(nxt_begin), .nxt_cfg(nxt_cfg)
  );

  lcd_com_drive #(.MAX_ROWS(MAX_ROWS), .IDX_W(IDX_W)) u_drive (
    .clk(clk), .rst(rst),
    .nxt_row(nxt_row), .nxt_first(nxt_first), .nxt_begin(nxt_begin), .nxt_cfg(nxt_cfg),
    .com_rev(com_rev), .seg_rev(seg_rev),
    .com_onehot(com_onehot), .row_idx(row_idx), .row_strobe(row_strobe),
    .frame_start(frame_start), .frame_pol(frame_pol), .icon_row(icon_row), .seg_dir(seg_dir)
  );
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
  parameter int MAX_ROWS = 25,
  parameter int IDX_W    = $clog2(MAX_ROWS)
) (
  input logic                clk,
  input logic                rst,
  input logic [MAX_ROWS-1:0] com_onehot,
  input logic [IDX_W-1:0]    row_idx,
  input logic                row_strobe,
  input logic                frame_start,
  input logic                frame_pol,
  input logic                seg_dir
);
  a_r4_start_on_strobe: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> row_strobe);

  a_r5_pol_flip: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !$past(rst)) |-> (frame_pol != $past(frame_pol)));

  a_r5_pol_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !$past(rst)) |-> $stable(frame_pol));

  a_r3_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (!row_strobe && !$past(rst)) |-> $stable(row_idx));

  a_r6_onehot_match: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(com_onehot) == 1 && com_onehot[row_idx]));

  a_r8_seg_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !$past(rst)) |-> $stable(seg_dir));
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.MAX_ROWS(MAX_ROWS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .com_onehot(com_onehot), .row_idx(row_idx),
  .row_strobe(row_strobe), .frame_start(frame_start), .frame_pol(frame_pol),
  .seg_dir(seg_dir)
);

// File: tb/test_lcd_com_scan.sv
module test_lcd_com_scan;
  localparam int MAX_ROWS = 25;
  localparam int IDX_W    = 5;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [2:0]          duty_sel = 3'd0;
  logic                com_rev = 1'b0;
  logic                seg_rev = 1'b0;
  logic [MAX_ROWS-1:0] com_onehot;
  logic [IDX_W-1:0]    row_idx;
  logic                row_strobe, frame_start, frame_pol, icon_row, seg_dir;

  always #4 clk = ~clk;

  lcd_com_scan i_lcd_com_scan (
    .clk(clk), .rst(rst), .duty_sel(duty_sel), .com_rev(com_rev), .seg_rev(seg_rev),
    .com_onehot(com_onehot), .row_idx(row_idx), .row_strobe(row_strobe),
    .frame_start(frame_start), .frame_pol(frame_pol), .icon_row(icon_row), .seg_dir(seg_dir)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, counted in rising edges since reset release
  bit m_run = 0;
  int m_edge = 0, m_base = 0, m_rows = 16, m_clks = 200, m_ext = 0;
  int m_rev = 0, m_srev = 0, m_pol = 0;
  bit m_changed = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, m_edge);
    end
  endtask

  // R2 R3: rows and row length per duty code
  task automatic duty_of(input logic [2:0] c, output int rows, output int clks, output int ext);
    case (c)
      3'd0: begin rows = 8;  clks = 400; ext = 0; end
      3'd1: begin rows = 9;  clks = 400; ext = 1; end
      3'd3: begin rows = 17; clks = 200; ext = 1; end
      3'd4: begin rows = 25; clks = 160; ext = 1; end
      default: begin rows = 16; clks = 200; ext = 0; end
    endcase
  endtask

  task automatic step_and_check();
    int pos, row, cp, idx;
    bit newf;
    if (rst) begin
      m_run = 0; m_pol = 0; m_srev = 0;
      chk("R1 com_onehot", int'(com_onehot), 0);
      chk("R1 row_idx", int'(row_idx), 0);
      chk("R1 row_strobe", int'(row_strobe), 0);
      chk("R1 frame_start", int'(frame_start), 0);
      chk("R1 frame_pol", int'(frame_pol), 0);
      chk("R1 icon_row", int'(icon_row), 0);
      chk("R1 seg_dir", int'(seg_dir), 0);
      return;
    end
    pos  = m_edge - m_base;
    newf = !m_run || (pos == m_rows * m_clks);
    if (newf) begin
      m_base = m_edge; pos = 0; m_run = 1;
      duty_of(duty_sel, m_rows, m_clks, m_ext);
      m_rev = int'(com_rev); m_srev = int'(seg_rev); m_pol ^= 1;
    end
    row = pos / m_clks;
    cp  = pos % m_clks;
    idx = (m_rev != 0) ? (m_rows - 1 - row) : row;
    chk("R4 frame_start", int'(frame_start), int'(pos == 0));
    chk("R3 row_strobe", int'(row_strobe), int'(cp == 0));
    chk("R2 R6 row_idx", int'(row_idx), idx);
    chk("R6 com_onehot", int'(com_onehot == (25'd1 << idx)), 1);
    chk("R5 frame_pol", int'(frame_pol), m_pol);
    chk("R7 icon_row", int'(icon_row), int'((m_ext != 0) && (idx == m_rows - 1)));
    chk("R8 seg_dir", int'(seg_dir), m_srev);
    if (newf && m_changed) begin
      m_changed = 0;
      // R9: latched settings switch only here
      chk("R9 new frame index", int'(row_idx), idx);
    end
    m_edge++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      step_and_check();
    end
  endtask

  initial begin
    run(3);
    // every duty code with several direction combinations, two frames each
    for (int c = 0; c < 5; c++) begin
      int rows, clks, ext;
      duty_sel = 3'(c);
      com_rev  = c[0];
      seg_rev  = c[1];
      duty_of(duty_sel, rows, clks, ext);
      rst = 1'b0;
      run(2 * rows * clks + 5);
      rst = 1'b1;
      run(2);
    end
    // R2: reserved code behaves as 16 rows
    duty_sel = 3'd6; com_rev = 1'b1; seg_rev = 1'b0;
    rst = 1'b0;
    run(16 * 200 + 5);
    rst = 1'b1;
    run(2);
    // R9: mid-frame change waits for the frame boundary
    duty_sel = 3'd0; com_rev = 1'b1; seg_rev = 1'b0;
    rst = 1'b0;
    run(1000);
    duty_sel = 3'd4; com_rev = 1'b0; seg_rev = 1'b1;
    m_changed = 1;
    run(2200 + 4000 + 10);
    // R1: reset in the middle of a frame restarts cleanly
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    run(50);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule